// File: doc/BRIEF.md
# Calibration Start-Up Busy Sequencer

This block controls start-up for a converter that calibrates itself. An external active-low initialization input, `init_n`, is sampled on the block clock through a two-flop synchronizer. A rising edge of that input starts the calibration interval, but only if the input was low for at least `MIN_LOW` clocks first. The rising edge is the trigger. The block has no power-on detection, so it reaches a defined state only after a valid low period has been seen.

During calibration the active-low `busy_n` output is held low for `CAL_CYCLES` clocks. After that it returns high and `ready` rises. Both outputs are always driven. A one-cycle `cal_start` strobe marks each accepted start, and a one-cycle `cal_done` strobe marks a completed interval.

A short glitch on the input is ignored. A valid low-then-high cycle during calibration discards the run and starts a new one. A long low during calibration first returns the block to the idle state.

Top module: `cal_busy_seq`

## Requirements
- R1: With the default `SYNC_STAGES`=2, suppose `init_n` rises after being low for at least `MIN_LOW` (default 3) clock cycles, and the rise falls between clock edges k-1 and k. Then `busy_n` is 0 and `cal_start` is 1 in the cycle that follows edge k+1, which is no later than two clocks after the rise.
- R2: Once the synchronized input has shown `MIN_LOW` consecutive low samples and is still low, the block enters idle on the next edge. In idle, `busy_n`=1, `ready`=0 and no strobe fires until an accepted rise.
- R3: `busy_n` stays low, and `ready` stays low, for exactly `CAL_CYCLES` consecutive cycles, counting the start cycle.
- R4: In the first cycle after the interval, `busy_n`=1, `ready`=1 and `cal_done`=1. `cal_done` fires only in that one cycle.
- R5: After completion, `ready` stays 1 and `busy_n` stays 1, with no strobes, until an accepted rise or a long low.
- R6: A low pulse on `init_n` shorter than `MIN_LOW` cycles has no effect. This holds in the ready state and during calibration, where the interval ends at its original time.
- R7: An accepted rise during calibration restarts the interval from its first cycle with a new `cal_start`. A low lasting past the `MIN_LOW` threshold during calibration aborts it into idle (R2) with no `cal_done`.
- R8: `cal_start` lasts one cycle and coincides with the cycle in which calibration begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| init_n | input | 1 | Active-low initialization request, asynchronous to clk |
| busy_n | output | 1 | Active-low calibration-in-progress flag |
| ready | output | 1 | High once calibration has completed |
| cal_start | output | 1 | One-cycle strobe when a calibration interval begins |
| cal_done | output | 1 | One-cycle strobe when a calibration interval completes |

## Verification
The bench drives `init_n` only on falling clock edges and counts rising edges. For each release at count c, it queues the expected output tuple for every cycle it cares about:
- the start strobe at c+2;
- calibration cycles through c+1+`CAL_CYCLES`;
- the done strobe at c+2+`CAL_CYCLES`.

For a long low starting at count a, idle is expected from a+6 onward, which allows for two synchronizer stages, the low counter and the state register. A monitor compares outputs on falling edges, only against entries stamped with the current count. An entry whose cycle passes without being matched is reported as a failure.

// File: rtl/cbs_pkg.sv
`timescale 1ns/1ps
package cbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CAL   = 2'd1,
        ST_READY = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cbs_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for the asynchronous init request.
module cbs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = din;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) sh_q <= sh_d;

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/cbs_lowtimer.sv
`timescale 1ns/1ps
// Qualifies the request: counts consecutive low samples, saturating.
module cbs_lowtimer #(
    parameter int MIN_LOW = 3
) (
    input  logic clk,
    input  logic sync_in,
    output logic launch,
    output logic hold_idle
);
    localparam int LW = $clog2(MIN_LOW + 1);

    logic [LW-1:0] cnt_d, cnt_q;
    logic          long_enough;

    assign long_enough = (cnt_q == LW'(MIN_LOW));

    always_comb begin
        if (sync_in)          cnt_d = '0;
        else if (long_enough) cnt_d = cnt_q;
        else                  cnt_d = cnt_q + LW'(1);
    end

    always_ff @(posedge clk) cnt_q <= cnt_d;

    assign launch    = sync_in & long_enough;
    assign hold_idle = ~sync_in & long_enough;
endmodule

// File: rtl/cbs_ctrl.sv
`timescale 1ns/1ps
// Calibration interval state machine and output decode.
module cbs_ctrl
    import cbs_pkg::*;
#(
    parameter int CAL_CYCLES = 750000
) (
    input  logic clk,
    input  logic launch,
    input  logic hold_idle,
    output logic busy_n,
    output logic ready,
    output logic cal_start,
    output logic cal_done
);
    localparam int CW   = $clog2(CAL_CYCLES);
    localparam int LAST = CAL_CYCLES - 1;

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          done;
    } ctrl_s;

    ctrl_s d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (launch) begin
            d.st  = ST_CAL;
            d.cnt = CW'(1);
        end else if (hold_idle) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
        end else begin
            case (q.st)
                ST_CAL: begin
                    if (q.cnt == CW'(LAST)) begin
                        d.st   = ST_READY;
                        d.cnt  = '0;
                        d.done = 1'b1;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                ST_READY: d.st = ST_READY;
                default:  d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) q <= d;

    assign busy_n    = ~((q.st == ST_CAL) | launch);
    assign ready     = (q.st == ST_READY) & ~launch;
    assign cal_start = launch;
    assign cal_done  = q.done;
endmodule

// File: rtl/cal_busy_seq.sv
`timescale 1ns/1ps
module cal_busy_seq #(
    parameter int CAL_CYCLES  = 750000,
    parameter int MIN_LOW     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic init_n,
    output logic busy_n,
    output logic ready,
    output logic cal_start,
    output logic cal_done
);
    logic init_sync;
    logic launch;
    logic hold_idle;

    cbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (init_n),
        .dout (init_sync)
    );

    cbs_lowtimer #(.MIN_LOW(MIN_LOW)) u_low (
        .clk       (clk),
        .sync_in   (init_sync),
        .launch    (launch),
        .hold_idle (hold_idle)
    );

    cbs_ctrl #(.CAL_CYCLES(CAL_CYCLES)) u_ctrl (
        .clk       (clk),
        .launch    (launch),
        .hold_idle (hold_idle),
        .busy_n    (busy_n),
        .ready     (ready),
        .cal_start (cal_start),
        .cal_done  (cal_done)
    );
endmodule

// File: rtl/cbs_checker.sv
`timescale 1ns/1ps
module cbs_checker #(
    parameter int CAL_CYCLES = 750000
) (
    input logic clk,
    input logic busy_n,
    input logic ready,
    input logic cal_start,
    input logic cal_done
);
    logic live_q = 1'b0;
    int   run_q  = 0;

    always_ff @(posedge clk) begin
        live_q <= 1'b1;
        if (cal_start)   run_q <= 1;
        else if (!busy_n) run_q <= run_q + 1;
    end

    a_r8_start_busy: assert property (@(posedge clk) disable iff (!live_q)
        cal_start |-> !busy_n);
    a_r8_fall_start: assert property (@(posedge clk) disable iff (!live_q)
        $fell(busy_n) |-> cal_start);
    a_r8_start_once: assert property (@(posedge clk) disable iff (!live_q)
        cal_start |=> !cal_start);
    a_r4_done_ready: assert property (@(posedge clk) disable iff (!live_q)
        cal_done |-> (busy_n && ready && $past(!busy_n)));
    a_r3_len: assert property (@(posedge clk) disable iff (!live_q)
        cal_done |-> (run_q == CAL_CYCLES));
    a_r5_ready_busy: assert property (@(posedge clk) disable iff (!live_q)
        ready |-> busy_n);
endmodule

bind cal_busy_seq cbs_checker #(.CAL_CYCLES(CAL_CYCLES)) u_chk (
    .clk       (clk),
    .busy_n    (busy_n),
    .ready     (ready),
    .cal_start (cal_start),
    .cal_done  (cal_done)
);

// File: tb/test_cal_busy_seq.sv
`timescale 1ns/1ps
module test_cal_busy_seq;
    localparam int CAL = 20;

    logic clk = 1'b0;
    logic init_n = 1'b1;
    logic busy_n, ready, cal_start, cal_done;
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   fin = 1'b0;

    always #2.5 clk = ~clk;

    cal_busy_seq #(.CAL_CYCLES(CAL), .MIN_LOW(3), .SYNC_STAGES(2)) i_cal_busy_seq (
        .clk       (clk),
        .init_n    (init_n),
        .busy_n    (busy_n),
        .ready     (ready),
        .cal_start (cal_start),
        .cal_done  (cal_done)
    );

    typedef struct {
        int    cyc;
        logic  b, r, s, d;
        string tag;
    } exp_t;

    exp_t sbq[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void push(int k, logic b, logic r, logic s, logic d, string t);
        exp_t e;
        e.cyc = k; e.b = b; e.r = r; e.s = s; e.d = d; e.tag = t;
        sbq.push_back(e);
    endfunction

    function automatic void span(int lo, int hi, logic b, logic r, logic s, logic d, string t);
        for (int k = lo; k <= hi; k++) push(k, b, r, s, d, t);
    endfunction

    // Expected outputs for an accepted release at cycle c
    function automatic void exp_cal(int c, string ts, string tm);
        push(c + 2, 1'b0, 1'b0, 1'b1, 1'b0, ts);
        span(c + 3, c + 1 + CAL, 1'b0, 1'b0, 1'b0, 1'b0, tm);
        push(c + 2 + CAL, 1'b1, 1'b1, 1'b0, 1'b1, "R4");
        span(c + 3 + CAL, c + 5 + CAL, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
    endfunction

    // Monitor: compare on falling edges against entries due this cycle
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].cyc == cyc) begin
                total++;
                if ({busy_n, ready, cal_start, cal_done} !==
                    {sbq[i].b, sbq[i].r, sbq[i].s, sbq[i].d}) begin
                    bad++;
                    $display("FAIL %s cycle %0d: actual busy_n/ready/start/done=%b%b%b%b expected=%b%b%b%b",
                             sbq[i].tag, cyc, busy_n, ready, cal_start, cal_done,
                             sbq[i].b, sbq[i].r, sbq[i].s, sbq[i].d);
                end
                sbq.delete(i);
            end else if (sbq[i].cyc < cyc) begin
                total++;
                bad++;
                $display("FAIL %s cycle %0d: actual=unchecked expected=checked", sbq[i].tag, sbq[i].cyc);
                sbq.delete(i);
            end
        end
    end

    task automatic wait_to(int k);
        while (cyc < k) @(negedge clk);
    endtask

    task automatic low_for(int n);
        init_n = 1'b0;
        repeat (n) @(negedge clk);
        init_n = 1'b1;
    endtask

    initial begin
        int a, c, t0, a2, c2, a3, c3;
        repeat (3) @(negedge clk);

        // S1: long low then release -> idle state, then full calibration (R2, R1, R3, R4, R5)
        @(negedge clk); a = cyc; c = a + 10;
        span(a + 7, c + 1, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        exp_cal(c, "R1,R8", "R3");
        low_for(10);
        wait_to(c + CAL + 6);

        // S2: short glitch while ready is ignored (R6)
        @(negedge clk); a = cyc;
        span(a + 1, a + 9, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
        low_for(2);
        wait_to(a + 10);

        // S3: exact minimum low from ready, then a glitch mid-calibration (R1, R6)
        @(negedge clk); a = cyc; c = a + 3;
        span(a + 1, c + 1, 1'b1, 1'b1, 1'b0, 1'b0, "R1");
        exp_cal(c, "R1,R8", "R6");
        low_for(3);
        wait_to(c + 8);
        low_for(2);
        wait_to(c + CAL + 6);

        // S4: valid restart mid-calibration (R7)
        @(negedge clk); a = cyc; c = a + 3; t0 = c + 2; a2 = t0 + 8; c2 = a2 + 3;
        push(t0, 1'b0, 1'b0, 1'b1, 1'b0, "R1,R8");
        span(t0 + 1, c2 + 1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        exp_cal(c2, "R7", "R7");
        low_for(3);
        wait_to(a2);
        low_for(3);
        wait_to(c2 + CAL + 6);

        // S5: long low mid-calibration aborts into idle, then recovers (R7, R2)
        @(negedge clk); a = cyc; c = a + 3; t0 = c + 2; a3 = t0 + 6; c3 = a3 + 8;
        push(t0, 1'b0, 1'b0, 1'b1, 1'b0, "R1,R8");
        span(t0 + 1, a3 + 5, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        span(a3 + 6, c3 + 1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        exp_cal(c3, "R1,R8", "R3");
        low_for(3);
        wait_to(a3);
        low_for(8);
        wait_to(c3 + CAL + 6);

        repeat (2) @(negedge clk);
        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule